// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Transfer Controller

This block pairs a bus master sequencer with a word-addressed memory target. The two share a single 16-bit bus that carries the address in one cycle and data in the cycles that follow. A local client starts a transaction with a one-cycle start pulse that carries an operation code, a start address, a beat count and a data word. The master then raises a bus request to an external arbiter and waits for the grant. Once granted, it runs one or two address phases, each followed by its data phases, and returns to idle.

Four operations are supported: incrementing block read, incrementing block write, atomic read-modify-write, and write with read-back check. During a data phase the target acknowledges every beat in the same cycle. It steps its latched address by one word after each acknowledged beat. Storage covers the lowest `DEPTH` addresses. Beats to higher addresses are still acknowledged, but they hold no data.

Top module: `mbus_xfer_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_req_o`, `bus_ale_o`, `bus_mrd_o`, `bus_mwr_o`, `done_o`, `cmp_err_o` and `busy_o` are all 0, and storage reads as zero.
- R2: `bus_req_o` rises in the cycle after an accepted start. No address strobe and no command line is asserted until `bus_gnt_i` has been seen high, however long the grant is withheld.
- R3: Each address phase lasts one cycle. In that cycle `bus_ale_o` is high, the address is on `bus_ad_o` and exactly one command line is high. The same command line stays high through the data phases that follow, and `bus_mrd_o` and `bus_mwr_o` are never high together.
- R4: `op_i`=0 (read) and `op_i`=1 (write) transfer `len_i`+1 beats behind a single address phase, at addresses start, start+1, and so on, wrapping modulo 2^16. Beat k of a write carries `wdata_i`+k modulo 2^16.
- R5: Addresses below `DEPTH` (64) hold data. A beat to any other address is still acknowledged, but a write there is dropped and a read returns 0.
- R6: `op_i`=2 (read-modify-write) reads the addressed word and then writes back old XOR `wdata_i` to the same address. It uses two address phases and two beats, and `bus_req_o` stays high without a gap from the first cycle to the last.
- R7: `op_i`=3 (write with read-back) writes `wdata_i` and then reads the same address. It uses two address phases, and `bus_req_o` stays high throughout. `cmp_err_o` pulses for one cycle, together with `done_o`, if and only if the value read back differs from `wdata_i`.
- R8: Every read beat gives one `rdata_valid_o` pulse, carrying the read word on `rdata_o` in the cycle after its acknowledge. `done_o` pulses for one cycle in the cycle after the last acknowledge, and `bus_req_o` falls in that same cycle.
- R9: A start pulse that arrives while `busy_o` is high is ignored. It adds no beats to the running transaction and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| op_i | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 write with read-back |
| addr_i | input | 16 | Start address |
| len_i | input | 4 | Beat count minus one (block operations) |
| wdata_i | input | 16 | Write base, XOR mask or check value |
| bus_gnt_i | input | 1 | Grant from external arbiter |
| bus_req_o | output | 1 | Request to external arbiter |
| bus_ale_o | output | 1 | Address phase strobe |
| bus_mrd_o | output | 1 | Memory read command |
| bus_mwr_o | output | 1 | Memory write command |
| bus_ack_o | output | 1 | Target beat acknowledge |
| bus_ad_o | output | 16 | Value on the shared address/data lines |
| busy_o | output | 1 | Transaction in progress |
| rdata_o | output | 16 | Last word read |
| rdata_valid_o | output | 1 | One pulse per read beat |
| done_o | output | 1 | Transaction finished |
| cmp_err_o | output | 1 | Read-back mismatch |

## Verification
The bench withholds the grant for many cycles and watches for any address strobe that slips out early, which would show a master that drives the bus before it owns it. It runs bursts that cross the end of storage, and a write burst whose data pattern wraps past 0xFFFF. A target that failed to step or decode its address would then read back shifted or ghost data. It also checks that a read-modify-write and a read-back each produce exactly two address strobes with no drop in the request, and that a read-back to an unmapped address raises the mismatch flag. A master that let a second start through mid-burst would show extra acknowledges and a stray write, and the bench looks for both.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_RMW = 2'd2,
    OP_RAW = 2'd3
  } mbus_op_e;

  typedef enum logic [1:0] {
    M_IDLE,
    M_REQ,
    M_ADDR,
    M_DATA
  } mst_state_e;
endpackage

// File: rtl/mbus_master.sv
module mbus_master
  import mbus_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  mbus_op_e      op_i,
  input  logic [DW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          gnt_i,
  input  logic          ack_i,
  input  logic [DW-1:0] ad_i,
  output logic          req_o,
  output logic          ale_o,
  output logic          mrd_o,
  output logic          mwr_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          busy_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          done_o,
  output logic          err_o
);
  mst_state_e    state_q;
  mbus_op_e      op_q;
  logic [DW-1:0] addr_q, wdata_q, rdata_q;
  logic [LW-1:0] left_q, idx_q;
  logic          wr_q, leg2_q, rvalid_q, done_q, err_q;
  logic          two_leg;
  logic          in_xfer;
  logic [DW-1:0] wr_word;

  assign two_leg = (op_q == OP_RMW) || (op_q == OP_RAW);
  assign in_xfer = (state_q == M_ADDR) || (state_q == M_DATA);

  always_comb begin
    case (op_q)
      OP_WR:   wr_word = wdata_q + DW'(idx_q);
      OP_RMW:  wr_word = rdata_q ^ wdata_q;
      default: wr_word = wdata_q;
    endcase
  end

  assign req_o    = (state_q != M_IDLE);
  assign busy_o   = req_o;
  assign ale_o    = (state_q == M_ADDR);
  assign mrd_o    = in_xfer && !wr_q;
  assign mwr_o    = in_xfer && wr_q;
  assign ad_oe_o  = ale_o || ((state_q == M_DATA) && wr_q);
  assign ad_o     = ale_o ? addr_q : (ad_oe_o ? wr_word : '0);
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= M_IDLE;
      op_q     <= OP_RD;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      left_q   <= '0;
      idx_q    <= '0;
      wr_q     <= 1'b0;
      leg2_q   <= 1'b0;
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      case (state_q)
        M_IDLE: if (start_i) begin
          op_q    <= op_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          left_q  <= (op_i == OP_RD || op_i == OP_WR) ? len_i : '0;
          idx_q   <= '0;
          leg2_q  <= 1'b0;
          wr_q    <= (op_i == OP_WR) || (op_i == OP_RAW);
          state_q <= M_REQ;
        end
        M_REQ:  if (gnt_i) state_q <= M_ADDR;
        M_ADDR: state_q <= M_DATA;
        M_DATA: if (ack_i) begin
          if (!wr_q) begin
            rdata_q  <= ad_i;
            rvalid_q <= 1'b1;
          end
          if (left_q != '0) begin
            left_q <= left_q - 1'b1;
            idx_q  <= idx_q + 1'b1;
          end else if (two_leg && !leg2_q) begin
            // second leg on the same address, bus kept
            leg2_q  <= 1'b1;
            wr_q    <= !wr_q;
            state_q <= M_ADDR;
          end else begin
            state_q <= M_IDLE;
            done_q  <= 1'b1;
            err_q   <= (op_q == OP_RAW) && (ad_i != wdata_q);
          end
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbus_target.sv
module mbus_target #(
  parameter int DW    = 16,
  parameter int DEPTH = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ale_i,
  input  logic          mrd_i,
  input  logic          mwr_i,
  input  logic [DW-1:0] ad_i,
  output logic          ack_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o
);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] lat_q;
  logic [DW-1:0] mem_q [DEPTH];
  logic          hit;
  logic [IW-1:0] idx;

  assign hit     = (lat_q >> IW) == '0;
  assign idx     = lat_q[IW-1:0];
  assign ack_o   = (mrd_i || mwr_i) && !ale_i;
  assign ad_oe_o = mrd_i && !ale_i;
  assign ad_o    = hit ? mem_q[idx] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (ale_i) lat_q <= ad_i;
      else if (ack_o) lat_q <= lat_q + 1'b1;
      if (ack_o && mwr_i && hit) mem_q[idx] <= ad_i;
    end
  end
endmodule

// File: rtl/mbus_xfer_top.sv
module mbus_xfer_top
  import mbus_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LW    = 4,
  parameter int DEPTH = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          bus_gnt_i,
  output logic          bus_req_o,
  output logic          bus_ale_o,
  output logic          bus_mrd_o,
  output logic          bus_mwr_o,
  output logic          bus_ack_o,
  output logic [DW-1:0] bus_ad_o,
  output logic          busy_o,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_valid_o,
  output logic          done_o,
  output logic          cmp_err_o
);
  logic [DW-1:0] mst_ad, tgt_ad, bus_ad;
  logic          mst_oe, tgt_oe;

  // shared lines: at most one driver, idle value zero
  assign bus_ad   = tgt_oe ? tgt_ad : (mst_oe ? mst_ad : '0);
  assign bus_ad_o = bus_ad;

  mbus_master #(.DW(DW), .LW(LW)) u_mst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_i     (mbus_op_e'(op_i)),
    .addr_i   (addr_i),
    .len_i    (len_i),
    .wdata_i  (wdata_i),
    .gnt_i    (bus_gnt_i),
    .ack_i    (bus_ack_o),
    .ad_i     (bus_ad),
    .req_o    (bus_req_o),
    .ale_o    (bus_ale_o),
    .mrd_o    (bus_mrd_o),
    .mwr_o    (bus_mwr_o),
    .ad_o     (mst_ad),
    .ad_oe_o  (mst_oe),
    .busy_o   (busy_o),
    .rdata_o  (rdata_o),
    .rvalid_o (rdata_valid_o),
    .done_o   (done_o),
    .err_o    (cmp_err_o)
  );

  mbus_target #(.DW(DW), .DEPTH(DEPTH)) u_tgt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ale_i   (bus_ale_o),
    .mrd_i   (bus_mrd_o),
    .mwr_i   (bus_mwr_o),
    .ad_i    (bus_ad),
    .ack_o   (bus_ack_o),
    .ad_o    (tgt_ad),
    .ad_oe_o (tgt_oe)
  );
endmodule

// File: rtl/mbus_xfer_chk.sv
module mbus_xfer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic bus_req_o,
  input logic bus_gnt_i,
  input logic bus_ale_o,
  input logic bus_mrd_o,
  input logic bus_mwr_o,
  input logic done_o,
  input logic cmp_err_o,
  input logic mst_oe,
  input logic tgt_oe
);
  a_r3_cmd_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_mrd_o && bus_mwr_o));
  a_r3_one_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mst_oe && tgt_oe));
  a_r2_drive_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ale_o || bus_mrd_o || bus_mwr_o) |-> (bus_req_o && bus_gnt_i));
  a_r2_req_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> bus_req_o);
  a_r3_ale_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ale_o |=> (!bus_ale_o && (bus_mrd_o || bus_mwr_o)));
  a_r3_cmd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ale_o |=> ($stable(bus_mwr_o) && $stable(bus_mrd_o)));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_err_o |-> done_o);
  a_r8_req_drop_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |-> done_o);
endmodule

bind mbus_xfer_top mbus_xfer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .bus_req_o (bus_req_o),
  .bus_gnt_i (bus_gnt_i),
  .bus_ale_o (bus_ale_o),
  .bus_mrd_o (bus_mrd_o),
  .bus_mwr_o (bus_mwr_o),
  .done_o    (done_o),
  .cmp_err_o (cmp_err_o),
  .mst_oe    (mst_oe),
  .tgt_oe    (tgt_oe)
);

// File: tb/mbus_xfer_top_bench.sv
`timescale 1ns/1ps
module mbus_xfer_top_bench;
  localparam int DEPTH = 64;
  localparam int NV    = 13;
  // {op, addr, len, wdata, expected cmp_err}
  localparam logic [38:0] VEC [NV] = '{
    {2'd1, 16'd4,   4'd3,  16'h1000, 1'b0},
    {2'd0, 16'd4,   4'd3,  16'h0000, 1'b0},
    {2'd0, 16'd2,   4'd0,  16'h0000, 1'b0},
    {2'd2, 16'd5,   4'd0,  16'h00FF, 1'b0},
    {2'd0, 16'd5,   4'd0,  16'h0000, 1'b0},
    {2'd3, 16'd9,   4'd0,  16'hA5A5, 1'b0},
    {2'd1, 16'd62,  4'd3,  16'hFFFE, 1'b0},
    {2'd0, 16'd61,  4'd4,  16'h0000, 1'b0},
    {2'd3, 16'd100, 4'd0,  16'h1234, 1'b1},
    {2'd3, 16'd200, 4'd0,  16'h0000, 1'b0},
    {2'd1, 16'd0,   4'd15, 16'h0100, 1'b0},
    {2'd0, 16'd0,   4'd15, 16'h0000, 1'b0},
    {2'd2, 16'd70,  4'd0,  16'hFFFF, 1'b0}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic [3:0]  len_i = '0;
  logic        bus_gnt_i = 1'b0;
  logic        bus_req_o, bus_ale_o, bus_mrd_o, bus_mwr_o, bus_ack_o;
  logic [15:0] bus_ad_o, rdata_o;
  logic        busy_o, rdata_valid_o, done_o, cmp_err_o;

  mbus_xfer_top u_mbus_xfer_top (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  logic [15:0] mdl [DEPTH];
  logic [15:0] got_q [32];
  logic [15:0] exp_q [32];
  int got_n, exp_n, ack_n, ale_n, gap_n;
  logic done_seen, err_seen, prev_req, gnt_block;
  int gwait;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // arbiter model: grant two cycles after request unless blocked
  initial begin
    gnt_block = 1'b0;
    gwait = 0;
    forever begin
      @(negedge clk_i);
      if (!bus_req_o) begin gwait = 0; bus_gnt_i = 1'b0; end
      else if (!gnt_block) begin
        gwait++;
        if (gwait >= 2) bus_gnt_i = 1'b1;
      end
    end
  end

  // port monitor
  initial begin
    prev_req = 1'b0;
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (bus_ale_o) ale_n++;
        if (bus_ack_o) ack_n++;
        if (rdata_valid_o && got_n < 32) begin got_q[got_n] = rdata_o; got_n++; end
        if (done_o) begin done_seen = 1'b1; err_seen = cmp_err_o; end
        if (prev_req && !bus_req_o && !done_o) gap_n++;
        prev_req = bus_req_o;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  function automatic logic [15:0] mrd(input logic [15:0] a);
    return (a < DEPTH) ? mdl[a[5:0]] : 16'h0;
  endfunction

  task automatic model(input logic [1:0] op, input logic [15:0] a, input logic [3:0] len,
                       input logic [15:0] wd);
    logic [15:0] old;
    exp_n = 0;
    case (op)
      2'd0: for (int i = 0; i <= int'(len); i++) begin
        exp_q[exp_n] = mrd(a + 16'(i)); exp_n++;
      end
      2'd1: for (int i = 0; i <= int'(len); i++) begin
        if ((a + 16'(i)) < DEPTH) mdl[6'(a + 16'(i))] = wd + 16'(i);
      end
      2'd2: begin
        old = mrd(a); exp_q[0] = old; exp_n = 1;
        if (a < DEPTH) mdl[a[5:0]] = old ^ wd;
      end
      default: begin
        if (a < DEPTH) mdl[a[5:0]] = wd;
        exp_q[0] = mrd(a); exp_n = 1;
      end
    endcase
  endtask

  task automatic kick(input logic [1:0] op, input logic [15:0] a, input logic [3:0] len,
                      input logic [15:0] wd);
    @(negedge clk_i); #1;
    got_n = 0; ack_n = 0; ale_n = 0; gap_n = 0;
    done_seen = 1'b0; err_seen = 1'b0;
    op_i = op; addr_i = a; len_i = len; wdata_i = wd; start_i = 1'b1;
    @(negedge clk_i); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400; i++) begin
      if (done_seen) break;
      @(negedge clk_i); #1;
    end
    chk(done_seen, "R8", "done pulse seen", int'(done_seen), 1);
  endtask

  task automatic check_txn(input logic [1:0] op, input logic [3:0] len, input bit exp_err);
    int exp_ack, exp_ale;
    exp_ack = (op < 2) ? int'(len) + 1 : 2;
    exp_ale = (op < 2) ? 1 : 2;
    chk(ack_n == exp_ack, "R4", "acknowledged beats", ack_n, exp_ack);
    chk(ale_n == exp_ale, "R3", "address phases", ale_n, exp_ale);
    chk(gap_n == 0, "R6", "request gap inside transaction", gap_n, 0);
    chk(err_seen == exp_err, "R7", "compare error", int'(err_seen), int'(exp_err));
    chk(got_n == exp_n, "R8", "read beat pulses", got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++)
      chk(got_q[k] == exp_q[k], (op == 2'd2) ? "R6" : (op == 2'd3) ? "R7" : "R5",
          $sformatf("read beat %0d", k), int'(got_q[k]), int'(exp_q[k]));
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    got_n = 0; ack_n = 0; ale_n = 0; gap_n = 0; exp_n = 0;
    done_seen = 1'b0; err_seen = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!bus_req_o && !bus_ale_o && !bus_mrd_o && !bus_mwr_o, "R1", "bus idle in reset",
        int'({bus_req_o, bus_ale_o, bus_mrd_o, bus_mwr_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(!busy_o && !done_o && !cmp_err_o && !bus_req_o, "R1", "idle after reset",
        int'({busy_o, done_o, cmp_err_o, bus_req_o}), 0);

    // vector walk: R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      logic [38:0] e;
      e = VEC[v];
      model(e[38:37], e[36:21], e[20:17], e[16:1]);
      kick(e[38:37], e[36:21], e[20:17], e[16:1]);
      wait_done();
      check_txn(e[38:37], e[20:17], e[0]);
    end

    // R2: grant withheld, no bus activity before grant
    gnt_block = 1'b1;
    model(2'd1, 16'd40, 4'd1, 16'hBEEF);
    kick(2'd1, 16'd40, 4'd1, 16'hBEEF);
    repeat (20) @(negedge clk_i);
    #1;
    chk(ale_n == 0, "R2", "address strobes while ungranted", ale_n, 0);
    chk(bus_req_o == 1'b1, "R2", "request held while waiting", int'(bus_req_o), 1);
    gnt_block = 1'b0;
    wait_done();
    check_txn(2'd1, 4'd1, 1'b0);
    model(2'd0, 16'd40, 4'd1, 16'h0);
    kick(2'd0, 16'd40, 4'd1, 16'h0);
    wait_done();
    check_txn(2'd0, 4'd1, 1'b0);

    // R9: second start while busy is dropped
    model(2'd0, 16'd0, 4'd7, 16'h0);
    kick(2'd0, 16'd0, 4'd7, 16'h0);
    repeat (3) @(negedge clk_i);
    #1;
    op_i = 2'd1; addr_i = 16'd30; len_i = 4'd0; wdata_i = 16'h7777; start_i = 1'b1;
    @(negedge clk_i); #1;
    start_i = 1'b0;
    wait_done();
    chk(ack_n == 8, "R9", "beats with ignored start", ack_n, 8);
    check_txn(2'd0, 4'd7, 1'b0);
    repeat (3) @(negedge clk_i);
    chk(!busy_o, "R9", "idle after ignored start", int'(busy_o), 0);
    model(2'd0, 16'd30, 4'd0, 16'h0);
    kick(2'd0, 16'd30, 4'd0, 16'h0);
    wait_done();
    chk(got_n == 1 && got_q[0] == 16'h0, "R9", "address 30 unwritten", int'(got_q[0]), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule